// File: doc/BRIEF.md
# Sliding-Window Anti-Replay Checker

This block decides, one request at a time, whether an incoming packet's 64-bit sequence number is fresh or must be dropped. It keeps the highest sequence number seen so far and a bitmap covering a window of `WIN` positions that reaches back from that highest number. A number newer than the highest is always taken, and the window slides forward to it. A number inside the window is taken only the first time it appears. A number older than the window's lower edge is refused.

Every refusal adds one to a drop counter. A separate 64-bit counter supplies outgoing sequence numbers and advances once for each transmit request. Each check is registered: the request is presented in one cycle and the verdict appears in the next.

Top module: `replay_window_guard`

## Requirements
- R1: While reset is asserted and right after it, `res_valid`, `res_accept`, `top_seq`, `tx_seq` and `drop_count` are all zero.
- R2: `res_valid` is high in exactly the cycle after a cycle with `chk_valid` high, and low otherwise.
- R3: The first request after reset is accepted whatever its value, and its number becomes `top_seq`.
- R4: A number greater than `top_seq` is accepted, and `top_seq` then equals that number.
- R5: A number `s` with `top_seq - s >= WIN` is refused, so the lowest acceptable value is `top_seq - WIN + 1`.
- R6: A number `s` with `0 <= top_seq - s < WIN` is accepted the first time it is seen since it entered the window, and refused on any later request. This includes `top_seq` itself.
- R7: A forward move by `d < WIN` keeps the marks of numbers that are still inside the window. A forward move by `d >= WIN` forgets all earlier marks.
- R8: `drop_count` rises by one on each refusal, in the same cycle the refusal shows on `res_accept`. An acceptance leaves it unchanged.
- R9: `tx_seq` rises by one after each cycle in which `tx_req` is high, and otherwise holds its value.
- R10: `top_seq` is stored as two 32-bit halves. Window arithmetic is exact across a carry from the low half into the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | A check request is present |
| chk_seq | input | 64 | Sequence number to check |
| tx_req | input | 1 | Advance the outgoing counter |
| res_valid | output | 1 | Verdict is valid this cycle |
| res_accept | output | 1 | 1 = accepted, 0 = refused |
| top_seq | output | 64 | Highest accepted sequence number |
| tx_seq | output | 64 | Outgoing sequence counter |
| drop_count | output | DROP_W | Number of refusals since reset |

## Verification
The hardest state to reach is a partly filled bitmap that is then moved forward by a distance smaller than the window. In that state some old marks must survive and others must fall off the end. Reaching it needs a long stream of closely spaced numbers that both repeat and advance. The bench therefore runs an instance with an eight-position window on pseudo-random streams whose spread is a few times the window size and whose base creeps forward. It checks every verdict against a set of previously accepted numbers, and it runs the same streams across a 32-bit carry boundary.

// File: rtl/replay_window_guard.sv
module replay_window_guard #(
  parameter int WIN    = 64,
  parameter int DROP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_valid,
  input  logic [63:0]       chk_seq,
  input  logic              tx_req,
  output logic              res_valid,
  output logic              res_accept,
  output logic [63:0]       top_seq,
  output logic [63:0]       tx_seq,
  output logic [DROP_W-1:0] drop_count
);
  localparam int IDX_W = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [WIN-1:0] ONE = {{(WIN-1){1'b0}}, 1'b1};
  localparam logic [63:0] WIN64 = 64'(WIN);

  logic [31:0]    top_lo, top_hi;
  logic           started;
  logic [WIN-1:0] seen;

  assign top_seq = {top_hi, top_lo};

  wire [63:0]      ahead  = chk_seq - top_seq;
  wire [63:0]      behind = top_seq - chk_seq;
  wire             is_new = chk_seq > top_seq;
  wire             in_win = !is_new && (behind < WIN64);
  wire [IDX_W-1:0] idx    = behind[IDX_W-1:0];
  wire             dup    = seen[idx];
  wire             take   = !started || is_new || (in_win && !dup);

  wire [WIN-1:0] slid = (ahead >= WIN64) ? '0 : (seen << ahead);
  wire [WIN-1:0] mark = ONE << idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      top_lo     <= '0;
      top_hi     <= '0;
      started    <= 1'b0;
      seen       <= '0;
      drop_count <= '0;
      tx_seq     <= '0;
    end else begin
      res_valid  <= chk_valid;
      res_accept <= chk_valid && take;
      if (tx_req) tx_seq <= tx_seq + 64'd1;
      if (chk_valid) begin
        if (!take) drop_count <= drop_count + 1'b1;
        if (!started || is_new) begin
          started <= 1'b1;
          top_lo  <= chk_seq[31:0];
          top_hi  <= chk_seq[63:32];
          seen    <= (started ? slid : '0) | ONE;
        end else if (take) begin
          seen <= seen | mark;
        end
      end
    end
  end
endmodule

// File: rtl/replay_window_guard_chk.sv
module replay_window_guard_chk #(
  parameter int WIN    = 64,
  parameter int DROP_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chk_valid,
  input logic [63:0]       chk_seq,
  input logic              tx_req,
  input logic              res_valid,
  input logic              res_accept,
  input logic [63:0]       top_seq,
  input logic [63:0]       tx_seq,
  input logic [DROP_W-1:0] drop_count,
  input logic              started
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> res_valid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !res_valid);
  assert_first_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !started) |=> (res_accept && top_seq == $past(chk_seq)));
  assert_newer_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && started && chk_seq > top_seq) |=> (res_accept && top_seq == $past(chk_seq)));
  assert_too_old_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && started && chk_seq <= top_seq && (top_seq - chk_seq) >= 64'(WIN)) |=> !res_accept);
  assert_drop_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_accept) |-> drop_count == $past(drop_count) + 1'b1);
  assert_drop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && !res_accept) |-> $stable(drop_count));
  assert_tx_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> tx_seq == $past(tx_seq) + 64'd1);
  assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_req |=> $stable(tx_seq));
  assert_top_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> top_seq >= $past(top_seq));
endmodule

bind replay_window_guard replay_window_guard_chk #(.WIN(WIN), .DROP_W(DROP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_seq(chk_seq), .tx_req(tx_req),
  .res_valid(res_valid), .res_accept(res_accept), .top_seq(top_seq), .tx_seq(tx_seq),
  .drop_count(drop_count), .started(started)
);

// File: tb/replay_window_guard_tb_top.sv
module replay_window_guard_tb_top;
  localparam int WIN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chk_valid = 1'b0;
  logic [63:0] chk_seq = '0;
  logic tx_req = 1'b0;
  logic res_valid, res_accept;
  logic [63:0] top_seq, tx_seq;
  logic [31:0] drop_count;

  int checks = 0;
  int failures = 0;

  bit          seen_m [logic [63:0]];
  bit          m_started;
  logic [63:0] m_top;
  int          m_drop;
  logic [63:0] m_tx;
  int unsigned lcg = 32'h1234_5678;

  always #5 clk = ~clk;

  replay_window_guard #(.WIN(WIN), .DROP_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_seq(chk_seq), .tx_req(tx_req),
    .res_valid(res_valid), .res_accept(res_accept), .top_seq(top_seq), .tx_seq(tx_seq),
    .drop_count(drop_count)
  );

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; chk_valid = 1'b0; tx_req = 1'b0;
    repeat (3) @(negedge clk);
    check(64'(res_valid), 0, "R1 res_valid");
    check(64'(res_accept), 0, "R1 res_accept");
    check(top_seq, 0, "R1 top_seq");
    check(tx_seq, 0, "R1 tx_seq");
    check(64'(drop_count), 0, "R1 drop_count");
    rst_n = 1'b1;
    seen_m.delete();
    m_started = 1'b0; m_top = '0; m_drop = 0; m_tx = '0;
  endtask

  task automatic send(input logic [63:0] s, input string req);
    bit exp;
    @(negedge clk);
    check(64'(res_valid), 0, "R2 idle res_valid");
    if (!m_started)              exp = 1'b1;
    else if (s > m_top)          exp = 1'b1;
    else if (m_top - s >= WIN)   exp = 1'b0;
    else                         exp = !seen_m.exists(s);
    if (exp) begin
      seen_m[s] = 1'b1;
      if (!m_started || s > m_top) m_top = s;
      m_started = 1'b1;
    end else m_drop++;
    chk_valid = 1'b1; chk_seq = s;
    @(negedge clk);
    chk_valid = 1'b0;
    check(64'(res_valid), 1, "R2 res_valid");
    check(64'(res_accept), 64'(exp), req);
    check(top_seq, m_top, {req, " top_seq"});
    check(64'(drop_count), 64'(m_drop), "R8 drop_count");
  endtask

  task automatic sweep(input logic [63:0] base, input int n, input string req);
    logic [63:0] b;
    b = base;
    for (int i = 0; i < n; i++) begin
      lcg = lcg * 1103515245 + 12345;
      if (lcg[20:19] == 2'b00) b = b + 64'(lcg[23:21]);
      send(b + 64'(lcg[30:16] % 32), req);
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    send(64'd100, "R3 first accepted");
    send(64'd100, "R6 top duplicate");
    send(64'd97,  "R6 in window new");
    send(64'd97,  "R6 in window repeat");
    send(64'd93,  "R6 lowest edge");
    send(64'd92,  "R5 just below edge");
    send(64'd103, "R4 forward by 3");
    send(64'd97,  "R7 mark kept after shift");
    send(64'd96,  "R7 unmarked still open");
    send(64'd95,  "R5 dropped off edge");
    send(64'd111, "R4 forward by window");
    send(64'd104, "R7 marks forgotten");
    send(64'd103, "R5 old top below edge");

    do_reset();
    send(64'd5, "R3 first small");
    send(64'd0, "R5 below at low end");
    send(64'd2, "R6 low end new");

    do_reset();
    send(64'h0000_0000_FFFF_FFFE, "R3 first near carry");
    send(64'h0000_0001_0000_0002, "R10 forward across carry");
    send(64'h0000_0000_FFFF_FFFF, "R10 in window across carry");
    send(64'h0000_0000_FFFF_FFFF, "R10 repeat across carry");
    send(64'h0000_0000_FFFF_FFFA, "R10 below edge across carry");
    check(top_seq, 64'h0000_0001_0000_0002, "R10 top halves");

    for (int k = 0; k < 37; k++) begin
      @(negedge clk);
      tx_req = (k % 3) != 1;
      if (tx_req) m_tx = m_tx + 1;
    end
    @(negedge clk);
    tx_req = 1'b0;
    check(tx_seq, m_tx, "R9 tx count");
    repeat (2) @(negedge clk);
    check(tx_seq, m_tx, "R9 tx hold");

    do_reset();
    sweep(64'd0, 700, "R6 sweep low");
    do_reset();
    sweep(64'h0000_0000_FFFF_FFE0, 700, "R10 sweep carry");
    do_reset();
    sweep(64'h0000_0100_0000_0000, 700, "R7 sweep high");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule